// File: doc/BRIEF.md
# Quarter-Phase Interpolated Pulse-Width Modulator

This block makes one pulse-width modulated output whose falling edge can land between two edges of its counter clock. It takes four copies of the same clock, each shifted by a quarter period. A coarse counter and a small state machine run on the zero-phase copy. They set the period and raise the output at the start of each period. The two lowest duty bits pick which shifted copy ends the pulse. The step of the pulse width is therefore one quarter of the counter clock period.

A control loop writes a duty word and a period setting at any time. The block takes both only at the start of a period, so a change made part-way through a period never cuts the pulse that is running. An enable input stops the output and clears the counter. The phase clocks are assumed to come from an ideal multi-phase source.

The state machine has five states:
- `ST_OFF`: disabled.
- `ST_HIGH`: the pulse is on and the coarse count has not yet reached its end.
- `ST_FINE`: the fine end is armed for one cycle.
- `ST_LOW`: the pulse has ended and the period has not yet finished.
- `ST_FULL`: the output is saturated high for the whole period.

Every period start re-decides the state from the newly taken duty word:
- A zero duty goes to `ST_LOW`.
- A saturating duty goes to `ST_FULL`.
- A zero coarse part goes to `ST_FINE`.
- Anything else goes to `ST_HIGH`.

Once the coarse count equals the coarse duty, `ST_HIGH` moves on. It goes to `ST_LOW` when the phase index is zero and to `ST_FINE` otherwise. `ST_FINE` always moves to `ST_LOW` on the next cycle. A low enable sends any state to `ST_OFF`. `ST_OFF` starts a new period on the first cycle that enable is high.

Top module: `quad_phase_dpwm`

## Requirements
- R1: While reset (active low, asynchronous) is asserted, the output is low. After reset is released with enable low, the output stays low.
- R2: Enable low forces the output low from the next zero-phase clock edge. When enable returns high, a new period starts, and the output rises on the first zero-phase edge that samples enable high (for a nonzero duty).
- R3: Rising edges are spaced P zero-phase clock periods apart, where P is the period setting. A setting below 2 is treated as 2.
- R4: The duty word is the coarse field (bits [9:2]) followed by the phase index (bits [1:0]). For a nonzero duty D whose coarse field is below P-1, the high time is D quarter clock periods.
- R5: A duty of zero keeps the output low for the whole period.
- R6: A coarse field at or above P-1 keeps the output high for the whole period, with no gap between periods.
- R7: Across all valid duty values for one period setting, the high time rises strictly with duty.
- R8: A duty word written while a pulse is running does not change that pulse. It applies from the next period start.
- R9: When the fine end is armed, exactly one phase-domain end flag is set at the next zero-phase edge. Otherwise none is set.
- R10: The coarse count always stays below the period value in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ph | input | 4 | Phase clocks; bit k lags bit 0 by k quarter periods |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces output low and clears the counter |
| duty_word | input | 10 | Coarse field [9:2], phase index [1:0] |
| period_cfg | input | 8 | Period in zero-phase clock cycles |
| pwm_out | output | 1 | Modulated output |

## Verification
Every valid duty for one period setting is swept. Each high time is measured to the picosecond and compared with the previous one. A wrong phase decode or a swapped phase clock would show up as a width off by a quarter step, or as a dip that breaks monotonic order. The edge cases are checked directly:
- Zero coarse field with a nonzero phase index: a design that waits a full coarse cycle gives a pulse one period too long.
- Saturating duty: a design that still arms the fine end drops a short notch into the next period.
- A duty changed during a running pulse: a design that does not hold the duty until the period start cuts that pulse short.
- Enable removed and restored: a design that does not clear the counter starts the next period late.

// File: rtl/dpwm_pkg.sv
`timescale 1ns/1ps
package dpwm_pkg;

    // Sequencer states of the coarse controller
    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_HIGH = 3'd1,
        ST_FINE = 3'd2,
        ST_LOW  = 3'd3,
        ST_FULL = 3'd4
    } dpwm_state_t;

    // Output level that a state drives on the zero-phase side
    function automatic logic state_is_high(input dpwm_state_t s);
        return (s == ST_HIGH) || (s == ST_FINE) || (s == ST_FULL);
    endfunction

endpackage

// File: rtl/dpwm_coarse_ctrl.sv
`timescale 1ns/1ps
module dpwm_coarse_ctrl
    import dpwm_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int FRAC_W = 2,
    localparam int DUTY_W = CNT_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DUTY_W-1:0] duty_word,
    input  logic [CNT_W-1:0]  period_cfg,
    output logic              hi_q,
    output logic              end_q,
    output logic [FRAC_W-1:0] frac_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  per_q,
    output dpwm_state_t       state_q
);

    localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(2);

    dpwm_state_t       state_nxt;
    logic [CNT_W-1:0]  cnt_nxt;
    logic [CNT_W-1:0]  per_eff;
    logic [CNT_W-1:0]  per_nxt;
    logic [CNT_W-1:0]  coarse_q;
    logic [CNT_W-1:0]  coarse_nxt;
    logic [FRAC_W-1:0] frac_nxt;
    logic [CNT_W-1:0]  coarse_in;
    logic [FRAC_W-1:0] frac_in;
    logic              wrap;

    // R3: a period setting below the minimum is raised to it
    assign per_eff   = (period_cfg < MIN_PER) ? MIN_PER : period_cfg;
    assign coarse_in = duty_word[DUTY_W-1:FRAC_W];
    assign frac_in   = duty_word[FRAC_W-1:0];

    // A new period starts on the last count or when leaving the idle state
    assign wrap = (state_q == ST_OFF) || (cnt_q == per_q - 1'b1);

    // R10: counter and R8: values taken only at a period start
    always_comb begin
        if (!en) begin
            cnt_nxt = '0;
        end else if (wrap) begin
            cnt_nxt = '0;
        end else begin
            cnt_nxt = cnt_q + 1'b1;
        end
        per_nxt    = wrap ? per_eff   : per_q;
        coarse_nxt = wrap ? coarse_in : coarse_q;
        frac_nxt   = wrap ? frac_in   : frac_q;
    end

    // Next-state decision
    always_comb begin
        state_nxt = state_q;
        if (!en) begin
            state_nxt = ST_OFF;
        end else if (wrap) begin
            if (duty_word == '0) begin
                state_nxt = ST_LOW;                      // R5
            end else if (coarse_in >= per_eff - 1'b1) begin
                state_nxt = ST_FULL;                     // R6
            end else if (coarse_in == '0) begin
                state_nxt = ST_FINE;
            end else begin
                state_nxt = ST_HIGH;
            end
        end else begin
            unique case (state_q)
                ST_HIGH: begin
                    if (cnt_nxt == coarse_q) begin
                        state_nxt = (frac_q == '0) ? ST_LOW : ST_FINE;
                    end
                end
                ST_FINE: state_nxt = ST_LOW;
                ST_LOW:  state_nxt = ST_LOW;
                ST_FULL: state_nxt = ST_FULL;
                ST_OFF:  state_nxt = ST_OFF;
                default: state_nxt = ST_OFF;
            endcase
        end
    end

    // State register with the counter and the period-start values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_OFF;
            cnt_q    <= '0;
            per_q    <= MIN_PER;
            coarse_q <= '0;
            frac_q   <= '0;
        end else begin
            state_q  <= state_nxt;
            cnt_q    <= cnt_nxt;
            per_q    <= per_nxt;
            coarse_q <= coarse_nxt;
            frac_q   <= frac_nxt;
        end
    end

    // Registered outputs decoded from the next state, free of decode glitches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q  <= 1'b0;
            end_q <= 1'b0;
        end else begin
            hi_q  <= state_is_high(state_nxt);
            end_q <= (state_nxt == ST_FINE);
        end
    end

endmodule

// File: rtl/dpwm_phase_end.sv
`timescale 1ns/1ps
module dpwm_phase_end #(
    parameter int PHASES = 4,
    localparam int FRAC_W = $clog2(PHASES)
) (
    input  logic [PHASES-1:0] clk_ph,
    input  logic              rst_n,
    input  logic              end_q,
    input  logic [FRAC_W-1:0] frac_q,
    output logic [PHASES-1:0] kill_vec
);

    // The zero phase never needs a fine end; the coarse side ends it
    assign kill_vec[0] = 1'b0;

    genvar k;
    generate
        for (k = 1; k < PHASES; k++) begin : g_phase
            logic kq;
            // R9: recapture the armed end on the selected shifted clock
            always_ff @(posedge clk_ph[k] or negedge rst_n) begin
                if (!rst_n) begin
                    kq <= 1'b0;
                end else begin
                    kq <= end_q && (frac_q == FRAC_W'(k));
                end
            end
            assign kill_vec[k] = kq;
        end
    endgenerate

endmodule

// File: rtl/quad_phase_dpwm.sv
`timescale 1ns/1ps
module quad_phase_dpwm
    import dpwm_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int PHASES = 4,
    localparam int FRAC_W = $clog2(PHASES),
    localparam int DUTY_W = CNT_W + FRAC_W
) (
    input  logic [PHASES-1:0] clk_ph,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DUTY_W-1:0] duty_word,
    input  logic [CNT_W-1:0]  period_cfg,
    output logic              pwm_out
);

    logic              hi_q;
    logic              end_q;
    logic [FRAC_W-1:0] frac_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  per_q;
    dpwm_state_t       state_q;
    logic [PHASES-1:0] kill_vec;

    dpwm_coarse_ctrl #(
        .CNT_W (CNT_W),
        .FRAC_W(FRAC_W)
    ) u_coarse (
        .clk       (clk_ph[0]),
        .rst_n     (rst_n),
        .en        (en),
        .duty_word (duty_word),
        .period_cfg(period_cfg),
        .hi_q      (hi_q),
        .end_q     (end_q),
        .frac_q    (frac_q),
        .cnt_q     (cnt_q),
        .per_q     (per_q),
        .state_q   (state_q)
    );

    dpwm_phase_end #(
        .PHASES(PHASES)
    ) u_phase (
        .clk_ph  (clk_ph),
        .rst_n   (rst_n),
        .end_q   (end_q),
        .frac_q  (frac_q),
        .kill_vec(kill_vec)
    );

    // R4: the coarse level is cut by whichever phase flag fires
    assign pwm_out = hi_q & ~(|kill_vec);

endmodule

// File: rtl/dpwm_checker.sv
`timescale 1ns/1ps
module dpwm_checker
    import dpwm_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int PHASES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              pwm_out,
    input logic              hi_q,
    input logic              end_q,
    input logic [PHASES-1:0] kill_vec,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  per_q,
    input dpwm_state_t       state_q
);

    // R2
    en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm_out);

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < per_q);

    // R9
    fine_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_q |-> ($countones(kill_vec) == 1));

    // R9
    kill_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !end_q |-> (kill_vec == '0));

    // R4
    fine_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_q |=> !hi_q);

    // R6
    full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL) |-> pwm_out);

endmodule

bind quad_phase_dpwm dpwm_checker #(
    .CNT_W (CNT_W),
    .PHASES(PHASES)
) u_chk (
    .clk     (clk_ph[0]),
    .rst_n   (rst_n),
    .en      (en),
    .pwm_out (pwm_out),
    .hi_q    (hi_q),
    .end_q   (end_q),
    .kill_vec(kill_vec),
    .cnt_q   (cnt_q),
    .per_q   (per_q),
    .state_q (state_q)
);

// File: tb/quad_phase_dpwm_test.sv
`timescale 1ns/1ps
module quad_phase_dpwm_test;

    localparam real TCLK = 5.0;
    localparam real TQ   = TCLK / 4.0;
    localparam int  NV   = 8;

    // Vectors: period setting, duty word, expected high time in ps
    localparam int VP[NV] = '{6, 6, 6, 6, 6, 10, 10, 20};
    localparam int VD[NV] = '{1, 2, 3, 4, 7, 22, 35, 61};
    localparam int VW[NV] = '{1250, 2500, 3750, 5000, 8750, 27500, 43750, 76250};

    logic c0, c1, c2, c3;
    logic [3:0] clk_ph;
    logic rst_n, en;
    logic [9:0] duty_word;
    logic [7:0] period_cfg;
    logic pwm_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    assign clk_ph = {c3, c2, c1, c0};

    initial begin c0 = 0; forever #(TCLK/2) c0 = ~c0; end
    initial begin c1 = 0; #(TQ);     forever #(TCLK/2) c1 = ~c1; end
    initial begin c2 = 0; #(2.0*TQ); forever #(TCLK/2) c2 = ~c2; end
    initial begin c3 = 0; #(3.0*TQ); forever #(TCLK/2) c3 = ~c3; end

    quad_phase_dpwm uut (
        .clk_ph    (clk_ph),
        .rst_n     (rst_n),
        .en        (en),
        .duty_word (duty_word),
        .period_cfg(period_cfg),
        .pwm_out   (pwm_out)
    );

    task automatic check_int(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input int per, input int duty);
        @(negedge c0);
        period_cfg = 8'(per);
        duty_word  = 10'(duty);
    endtask

    task automatic settle(input int per);
        repeat (2 * per + 2) @(posedge c0);
        #1;
    endtask

    task automatic measure_ps(output int w);
        realtime t0;
        @(posedge pwm_out);
        t0 = $realtime;
        @(negedge pwm_out);
        w = int'(($realtime - t0) * 1000.0);
    endtask

    task automatic count_high(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            #1;
            if (pwm_out) highs++;
        end
    endtask

    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int w, prev, highs;
        realtime ta;
        rst_n = 0; en = 0; duty_word = 10'd20; period_cfg = 8'd10;
        #12;
        // R1: low under reset
        check_int(pwm_out == 1'b0, "R1", pwm_out, 0);
        @(negedge c0); rst_n = 1;
        count_high(30, highs);
        check_int(highs == 0, "R1", highs, 0);
        @(negedge c0); en = 1;

        // R4: vector table
        for (int v = 0; v < NV; v++) begin
            apply(VP[v], VD[v]);
            settle(VP[v]);
            measure_ps(w);
            check_int(w > VW[v] - 10 && w < VW[v] + 10, "R4", w, VW[v]);
        end

        // R4 and R7: full sweep at period 6
        prev = 0;
        apply(6, 1);
        for (int d = 1; d <= 19; d++) begin
            apply(6, d);
            settle(6);
            measure_ps(w);
            check_int(w > d * 1250 - 10 && w < d * 1250 + 10, "R4", w, d * 1250);
            if (d > 1) check_int(w > prev, "R7", w, prev + 1);
            prev = w;
        end

        // R3: spacing of rising edges
        apply(7, 9);
        settle(7);
        @(posedge pwm_out); ta = $realtime;
        @(posedge pwm_out);
        w = int'(($realtime - ta) * 1000.0);
        check_int(w > 34990 && w < 35010, "R3", w, 35000);
        apply(1, 1);
        settle(2);
        @(posedge pwm_out); ta = $realtime;
        @(posedge pwm_out);
        w = int'(($realtime - ta) * 1000.0);
        check_int(w > 9990 && w < 10010, "R3", w, 10000);

        // R5: zero duty
        apply(6, 0);
        settle(6);
        count_high(60, highs);
        check_int(highs == 0, "R5", highs, 0);

        // R6: saturation at coarse = P-1 and at the top code
        apply(6, 20);
        settle(6);
        count_high(60, highs);
        check_int(highs == 60, "R6", highs, 60);
        apply(6, 1023);
        settle(6);
        count_high(60, highs);
        check_int(highs == 60, "R6", highs, 60);

        // R8: change during a running pulse
        apply(10, 20);
        settle(10);
        @(posedge pwm_out); ta = $realtime;
        #1 duty_word = 10'd8;
        @(negedge pwm_out);
        w = int'(($realtime - ta) * 1000.0);
        check_int(w > 24990 && w < 25010, "R8", w, 25000);
        measure_ps(w);
        check_int(w > 9990 && w < 10010, "R8", w, 10000);

        // R2: enable off and back on
        apply(10, 20);
        settle(10);
        @(negedge c0); en = 0;
        @(posedge c0); #1;
        check_int(pwm_out == 1'b0, "R2", pwm_out, 0);
        count_high(40, highs);
        check_int(highs == 0, "R2", highs, 0);
        @(negedge c0); en = 1;
        @(posedge c0); #0.5;
        check_int(pwm_out == 1'b1, "R2", pwm_out, 1);
        @(negedge pwm_out);
        measure_ps(w);
        check_int(w > 24990 && w < 25010, "R2", w, 25000);

        // R1: reset during a pulse drops the output at once
        @(posedge pwm_out); #2;
        rst_n = 0; #0.5;
        check_int(pwm_out == 1'b0, "R1", pwm_out, 0);
        #10;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule